// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles control-flow instructions for a register virtual machine with 64-bit registers. Each cycle it can accept one instruction. The instruction is given as an 8-bit opcode, a 4-bit source-register field, the two register operands, a 32-bit immediate, a 16-bit signed slot offset and the program counter of that instruction.

The block decodes the opcode and evaluates the branch condition, either over the full register width or over the low half only. It then registers the program counter of the next instruction together with a one-cycle result strobe. Call and exit instructions do not produce a branch result. Instead they pulse a flag that tells a separate sequencer what happened, and the block then stalls until that sequencer acknowledges.

The low three opcode bits select the instruction class: 3'b101 is full-width and 3'b110 is half-width. Opcode bit 3 picks the second operand. The high nibble picks the condition.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, every strobe output is low, `stall` is low, and both `next_pc` and `call_kind` are zero.
- R2: In the full-width class (low three opcode bits 3'b101), these high nibbles give the following unsigned and equality conditions: 1 is equal, 5 is not-equal, 2 is greater, 3 is greater-or-equal, 0xA is less, 0xB is less-or-equal.
- R3: In either class, high nibbles 6, 7, 0xC and 0xD compare two's-complement values. They are greater, greater-or-equal, less and less-or-equal, in that order.
- R4: High nibble 4 is a bit test. The branch is taken exactly when the AND of the two operands has any bit set.
- R5: In the half-width class (low three bits 3'b110), only bits 31:0 of each operand take part. For signed conditions, bit 31 is the sign.
- R6: When opcode bit 3 is 0, the second operand is the immediate, sign-extended from bit 31 to the register width. When opcode bit 3 is 1, the second operand is `src_val`.
- R7: One cycle after an accepted branch, `next_pc` holds one of two values. If the branch is taken, it is `pc_in + 1 + offset` (offset sign-extended). If not taken, it is `pc_in + 1`. Opcode 0x05 is always taken.
- R8: Opcode 0x85 with a source field of 0, 1 or 2 produces a one-cycle `call_pulse`. That source field appears on `call_kind` (0 helper, 1 local function, 2 runtime function). `next_pc` takes the call's own PC. `stall` then stays high, and every `in_valid` is ignored, until a cycle with `seq_ack` high.
- R9: Opcode 0x95 produces a one-cycle `exit_pulse`. `next_pc` takes the exit's own PC, and `stall` follows the same rule as in R8.
- R10: An undefined encoding inside either class produces a one-cycle `illegal` pulse and leaves `next_pc` unchanged. The undefined encodings are: high nibble 0xE or 0xF; in the half-width class, high nibble 0, 8 or 9; in the full-width class, high nibble 0, 8 or 9 with bit 3 set; and a call whose source field is above 2.
- R11: An opcode outside both classes raises no strobe and leaves `next_pc` unchanged.
- R12: An accepted branch raises `res_valid` for one cycle, with `taken` giving the outcome. At most one of `res_valid`, `illegal`, `call_pulse` and `exit_pulse` is high in any cycle, and `taken` is high only together with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Instruction opcode |
| src_field | input | 4 | Source-register field of the instruction |
| dst_val | input | XLEN | First operand value |
| src_val | input | XLEN | Register second operand |
| imm | input | 32 | Immediate, sign-extended internally |
| offset | input | 16 | Signed branch displacement in instruction slots |
| pc_in | input | PCW | PC of the presented instruction |
| seq_ack | input | 1 | Sequencer releases a call or exit stall |
| next_pc | output | PCW | Registered PC of the following instruction |
| res_valid | output | 1 | Branch result strobe |
| taken | output | 1 | Branch outcome, valid with res_valid |
| illegal | output | 1 | Undefined encoding strobe |
| call_pulse | output | 1 | Call strobe |
| call_kind | output | 2 | Variant of the last call |
| exit_pulse | output | 1 | Exit strobe |
| stall | output | 1 | Waiting for sequencer acknowledge |

## Verification
Every output is a register loaded from the cycle's inputs. A wrong decode, a wrong width fold or a wrong comparison therefore shows on `taken` or `next_pc` one clock after the instruction. A wrong stall state shows as a strobe that should not be there, or as a missing strobe, on the first instruction presented afterwards. The reference model predicts every output on every cycle, so a corrupted state is reported within one cycle of the point where it becomes visible.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [3:0] {
    C_EQ, C_NE, C_UGT, C_UGE, C_ULT, C_ULE,
    C_SGT, C_SGE, C_SLT, C_SLE, C_SET, C_ALWAYS
  } cond_e;

  typedef enum logic [2:0] {
    K_OTHER, K_BRANCH, K_CALL, K_EXIT, K_ILLEGAL
  } kind_e;

  typedef struct packed {
    kind_e kind;
    cond_e cond;
    logic  use_reg;
    logic  narrow;
  } dec_t;

  localparam logic [2:0] CLS_WIDE   = 3'b101;
  localparam logic [2:0] CLS_NARROW = 3'b110;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [7:0] op,
  input  logic [3:0] src_field,
  output dec_t       dec
);
  logic [3:0] hi;
  logic [2:0] cls;
  logic       regsel;

  assign hi     = op[7:4];
  assign cls    = op[2:0];
  assign regsel = op[3];

  always_comb begin
    dec.kind    = K_OTHER;
    dec.cond    = C_ALWAYS;
    dec.use_reg = regsel;
    dec.narrow  = (cls == CLS_NARROW);
    if (cls == CLS_WIDE || cls == CLS_NARROW) begin
      dec.kind = K_BRANCH;
      unique case (hi)
        4'h1: dec.cond = C_EQ;
        4'h5: dec.cond = C_NE;
        4'h2: dec.cond = C_UGT;
        4'h3: dec.cond = C_UGE;
        4'ha: dec.cond = C_ULT;
        4'hb: dec.cond = C_ULE;
        4'h6: dec.cond = C_SGT;
        4'h7: dec.cond = C_SGE;
        4'hc: dec.cond = C_SLT;
        4'hd: dec.cond = C_SLE;
        4'h4: dec.cond = C_SET;
        4'h0: if (dec.narrow || regsel) dec.kind = K_ILLEGAL;
        4'h8: dec.kind = (!dec.narrow && !regsel && src_field <= 4'd2)
                         ? K_CALL : K_ILLEGAL;
        4'h9: dec.kind = (!dec.narrow && !regsel) ? K_EXIT : K_ILLEGAL;
        default: dec.kind = K_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            narrow,
  input  cond_e           cond,
  output logic            hit
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] au, bu, as_, bs_;

  // Fold half-width operands onto the full-width comparator:
  // zero-extend for unsigned tests, sign-extend for signed tests.
  always_comb begin
    if (narrow) begin
      au  = {{HALF{1'b0}}, a[HALF-1:0]};
      bu  = {{HALF{1'b0}}, b[HALF-1:0]};
      as_ = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
      bs_ = {{HALF{b[HALF-1]}}, b[HALF-1:0]};
    end else begin
      au  = a;
      bu  = b;
      as_ = a;
      bs_ = b;
    end
  end

  always_comb begin
    unique case (cond)
      C_EQ:    hit = (au == bu);
      C_NE:    hit = (au != bu);
      C_UGT:   hit = (au > bu);
      C_UGE:   hit = (au >= bu);
      C_ULT:   hit = (au < bu);
      C_ULE:   hit = (au <= bu);
      C_SGT:   hit = ($signed(as_) > $signed(bs_));
      C_SGE:   hit = ($signed(as_) >= $signed(bs_));
      C_SLT:   hit = ($signed(as_) < $signed(bs_));
      C_SLE:   hit = ($signed(as_) <= $signed(bs_));
      C_SET:   hit = |(au & bu);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int PCW = 32
) (
  input  logic [PCW-1:0] pc,
  input  logic [15:0]    off,
  input  logic           jump,
  output logic [PCW-1:0] npc
);
  logic [PCW-1:0] seq, disp;

  generate
    if (PCW > 16) begin : g_sext
      assign disp = {{(PCW-16){off[15]}}, off};
    end else begin : g_trunc
      assign disp = off[PCW-1:0];
    end
  endgenerate

  assign seq = pc + PCW'(1);
  assign npc = jump ? seq + disp : seq;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PCW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      opcode,
  input  logic [3:0]      src_field,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [31:0]     imm,
  input  logic [15:0]     offset,
  input  logic [PCW-1:0]  pc_in,
  input  logic            seq_ack,
  output logic [PCW-1:0]  next_pc,
  output logic            res_valid,
  output logic            taken,
  output logic            illegal,
  output logic            call_pulse,
  output logic [1:0]      call_kind,
  output logic            exit_pulse,
  output logic            stall
);
  dec_t            dec;
  logic [XLEN-1:0] opnd_b;
  logic            hit;
  logic [PCW-1:0]  tgt;
  logic            accept;

  bru_decode u_dec (.op(opcode), .src_field(src_field), .dec(dec));

  assign opnd_b = dec.use_reg ? src_val : {{(XLEN-32){imm[31]}}, imm};

  bru_cond #(.XLEN(XLEN)) u_cond (
    .a(dst_val), .b(opnd_b), .narrow(dec.narrow), .cond(dec.cond), .hit(hit)
  );

  bru_target #(.PCW(PCW)) u_tgt (
    .pc(pc_in), .off(offset), .jump(hit), .npc(tgt)
  );

  assign accept = in_valid && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc    <= '0;
      res_valid  <= 1'b0;
      taken      <= 1'b0;
      illegal    <= 1'b0;
      call_pulse <= 1'b0;
      call_kind  <= 2'd0;
      exit_pulse <= 1'b0;
      stall      <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      taken      <= 1'b0;
      illegal    <= 1'b0;
      call_pulse <= 1'b0;
      exit_pulse <= 1'b0;
      if (stall && seq_ack) stall <= 1'b0;
      if (accept) begin
        unique case (dec.kind)
          K_BRANCH: begin
            res_valid <= 1'b1;
            taken     <= hit;
            next_pc   <= tgt;
          end
          K_CALL: begin
            call_pulse <= 1'b1;
            call_kind  <= src_field[1:0];
            stall      <= 1'b1;
            next_pc    <= pc_in;
          end
          K_EXIT: begin
            exit_pulse <= 1'b1;
            stall      <= 1'b1;
            next_pc    <= pc_in;
          end
          K_ILLEGAL: illegal <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

module bru_checker #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [7:0]     opcode,
  input logic [PCW-1:0] pc_in,
  input logic [PCW-1:0] next_pc,
  input logic           res_valid,
  input logic           taken,
  input logic           illegal,
  input logic           call_pulse,
  input logic [1:0]     call_kind,
  input logic           exit_pulse,
  input logic           stall
);
  logic in_class;
  assign in_class = (opcode[2:0] == 3'b101) || (opcode[2:0] == 3'b110);

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid, illegal, call_pulse, exit_pulse}));

  a_r12_taken_with_valid: assert property (@(posedge clk) disable iff (rst)
    taken |-> res_valid);

  a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
    res_valid && !taken |-> next_pc == $past(pc_in) + PCW'(1));

  a_r10_pc_kept: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(next_pc));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    stall |=> !res_valid && !illegal && !call_pulse && !exit_pulse);

  a_r8_call_stalls: assert property (@(posedge clk) disable iff (rst)
    call_pulse |-> stall && call_kind <= 2'd2);

  a_r9_exit_stalls: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |-> stall);

  a_r11_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_class |=> !res_valid && !illegal && !call_pulse
                              && !exit_pulse && $stable(next_pc));
endmodule

bind branch_resolve_unit bru_checker #(.PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .pc_in(pc_in),
  .next_pc(next_pc), .res_valid(res_valid), .taken(taken), .illegal(illegal),
  .call_pulse(call_pulse), .call_kind(call_kind), .exit_pulse(exit_pulse),
  .stall(stall)
);

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb;
  localparam int XLEN = 64;
  localparam int PCW  = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [7:0]      opcode = 8'h00;
  logic [3:0]      src_field = 4'd0;
  logic [XLEN-1:0] dst_val = '0, src_val = '0;
  logic [31:0]     imm = '0;
  logic [15:0]     offset = '0;
  logic [PCW-1:0]  pc_in = '0;
  logic            seq_ack = 1'b0;
  logic [PCW-1:0]  next_pc;
  logic            res_valid, taken, illegal, call_pulse, exit_pulse, stall;
  logic [1:0]      call_kind;

  int vectors = 0;
  int fails = 0;

  // expected state
  logic [PCW-1:0] e_pc = '0;
  logic e_rv = 0, e_tk = 0, e_il = 0, e_call = 0, e_exit = 0, e_stall = 0;
  logic [1:0] e_kind = 0;
  string tk_tag = "R2";

  always #5 clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN), .PCW(PCW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .src_field(src_field), .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .offset(offset), .pc_in(pc_in), .seq_ack(seq_ack), .next_pc(next_pc),
    .res_valid(res_valid), .taken(taken), .illegal(illegal),
    .call_pulse(call_pulse), .call_kind(call_kind), .exit_pulse(exit_pulse),
    .stall(stall)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned got, input longint unsigned exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // 0 other, 1 branch, 2 call, 3 exit, 4 undefined
  function automatic int classify(input logic [7:0] op, input logic [3:0] sf);
    bit wide = (op[2:0] == 3'b101);
    bit half = (op[2:0] == 3'b110);
    if (!wide && !half) return 0;
    if (op == 8'h85) return (sf < 3) ? 2 : 4;
    if (op == 8'h95) return 3;
    if (op == 8'h05) return 1;
    case (op[7:4])
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
      4'ha, 4'hb, 4'hc, 4'hd: return 1;
      default: return 4;
    endcase
  endfunction

  function automatic bit ref_taken(input logic [7:0] op, input logic [63:0] d,
                                   input logic [63:0] s, input logic [31:0] im);
    logic [63:0] b = op[3] ? s : {{32{im[31]}}, im};
    longint unsigned ua, ub;
    longint sa, sb;
    if (op == 8'h05) return 1;
    if (op[2:0] == 3'b110) begin
      ua = longint'(d[31:0]);  ub = longint'(b[31:0]);
      sa = longint'(int'(d[31:0])); sb = longint'(int'(b[31:0]));
    end else begin
      ua = d; ub = b; sa = longint'(d); sb = longint'(b);
    end
    case (op[7:4])
      4'h1: return ua == ub;
      4'h5: return ua != ub;
      4'h2: return ua > ub;
      4'h3: return ua >= ub;
      4'ha: return ua < ub;
      4'hb: return ua <= ub;
      4'h6: return sa > sb;
      4'h7: return sa >= sb;
      4'hc: return sa < sb;
      4'hd: return sa <= sb;
      4'h4: return (ua & ub) != 0;
      default: return 0;
    endcase
  endfunction

  // predict, clock, compare
  task automatic step();
    int c;
    bit acc = in_valid && !e_stall;
    bit t;
    c = classify(opcode, src_field);
    t = ref_taken(opcode, dst_val, src_val, imm);
    if (e_stall && seq_ack) e_stall = 0;
    e_rv = 0; e_tk = 0; e_il = 0; e_call = 0; e_exit = 0;
    if (acc) begin
      case (c)
        1: begin
          e_rv = 1; e_tk = t;
          e_pc = pc_in + 1 + (t ? {{16{offset[15]}}, offset} : 32'd0);
          if (opcode[2:0] == 3'b110) tk_tag = "R5";
          else if (!opcode[3] && imm[31]) tk_tag = "R6";
          else if (opcode[7:4] inside {4'h6, 4'h7, 4'hc, 4'hd}) tk_tag = "R3";
          else if (opcode[7:4] == 4'h4) tk_tag = "R4";
          else tk_tag = "R2";
        end
        2: begin e_call = 1; e_kind = src_field[1:0]; e_stall = 1; e_pc = pc_in; end
        3: begin e_exit = 1; e_stall = 1; e_pc = pc_in; end
        4: e_il = 1;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk(res_valid === e_rv, "R12", "res_valid", 64'(res_valid), 64'(e_rv));
    chk(taken === e_tk, tk_tag, "taken", 64'(taken), 64'(e_tk));
    chk(next_pc === e_pc, (c == 4) ? "R10" : (c == 0 ? "R11" : "R7"),
        "next_pc", 64'(next_pc), 64'(e_pc));
    chk(illegal === e_il, "R10", "illegal", 64'(illegal), 64'(e_il));
    chk(call_pulse === e_call, "R8", "call_pulse", 64'(call_pulse), 64'(e_call));
    chk(call_kind === e_kind, "R8", "call_kind", 64'(call_kind), 64'(e_kind));
    chk(exit_pulse === e_exit, "R9", "exit_pulse", 64'(exit_pulse), 64'(e_exit));
    chk(stall === e_stall, "R8", "stall", 64'(stall), 64'(e_stall));
  endtask

  task automatic drive(input logic [7:0] op, input logic [63:0] d,
                       input logic [63:0] s, input logic [31:0] im,
                       input logic [15:0] off, input logic [3:0] sf);
    in_valid = 1; opcode = op; dst_val = d; src_val = s; imm = im;
    offset = off; src_field = sf; pc_in = pc_in + 32'd7;
    step();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    pc_in = 32'h100;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(next_pc === '0 && !res_valid && !taken && !illegal && !call_pulse
        && !exit_pulse && !stall && call_kind === 2'd0,
        "R1", "reset outputs", 64'(next_pc), 64'd0);
    rst = 0;
    @(negedge clk);
    chk(next_pc === '0 && !stall, "R1", "after reset", 64'(next_pc), 64'd0);

    // R2 unsigned and equality, full width
    drive(8'h1d, 64'h5, 64'h5, 0, 16'd3, 0);
    drive(8'h5d, 64'h5, 64'h5, 0, 16'd3, 0);
    drive(8'h2d, 64'hffff_0000_0000_0000, 64'h1, 0, 16'hfffe, 0);
    drive(8'had, 64'hffff_0000_0000_0000, 64'h1, 0, 16'h10, 0);
    drive(8'h3d, 64'h7, 64'h7, 0, 16'h2, 0);
    drive(8'hbd, 64'h8, 64'h7, 0, 16'h2, 0);
    // R3 signed
    drive(8'h6d, 64'hffff_ffff_ffff_ffff, 64'h1, 0, 16'h4, 0);
    drive(8'hcd, 64'hffff_ffff_ffff_ffff, 64'h1, 0, 16'h4, 0);
    drive(8'h7d, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 16'h1, 0);
    drive(8'hdd, 64'h2, 64'h1, 0, 16'h1, 0);
    // R4 bit test
    drive(8'h4d, 64'hf0, 64'h0f, 0, 16'h9, 0);
    drive(8'h45, 64'h1_0000_0000, 0, 32'h8000_0000, 16'h9, 0);
    // R6 immediate sign extension: -1 against all-ones
    drive(8'h15, 64'hffff_ffff_ffff_ffff, 0, 32'hffff_ffff, 16'h5, 0);
    drive(8'h25, 64'h0000_0000_ffff_ffff, 0, 32'hffff_ffff, 16'h5, 0);
    // R5 half width ignores upper bits
    drive(8'h1e, 64'hdead_0000_0000_0042, 64'hbeef_0000_0000_0042, 0, 16'h6, 0);
    drive(8'h66, 64'h0000_0001_8000_0000, 64'h0, 0, 16'h6, 0);
    drive(8'ha6, 64'h0000_0001_0000_0000, 0, 32'h1, 16'h6, 0);
    // R7 unconditional jump, negative offset
    drive(8'h05, 0, 0, 0, 16'h8000, 0);
    // R10 undefined encodings
    drive(8'he5, 0, 0, 0, 16'h1, 0);
    drive(8'h06, 0, 0, 0, 16'h1, 0);
    drive(8'h0d, 0, 0, 0, 16'h1, 0);
    drive(8'h85, 0, 0, 0, 16'h1, 4'd3);
    // R11 foreign classes
    drive(8'h07, 1, 1, 1, 16'h1, 0);
    drive(8'hb7, 1, 1, 1, 16'h1, 0);
    // R8 call variants with stall and acknowledge
    for (int k = 0; k < 3; k++) begin
      drive(8'h85, 0, 0, 0, 0, 4'(k));
      drive(8'h1d, 1, 1, 0, 16'h3, 0);      // ignored while stalled
      seq_ack = 1; in_valid = 0; step(); seq_ack = 0;
    end
    // R9 exit
    drive(8'h95, 0, 0, 0, 0, 0);
    drive(8'h95, 0, 0, 0, 0, 0);
    seq_ack = 1; step(); seq_ack = 0;

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick = 3'($urandom_range(0, 7));
      logic [3:0] lo;
      logic [63:0] d, s;
      case (pick)
        0, 1, 2: lo = 4'h5;
        3: lo = 4'hd;
        4: lo = 4'h6;
        5: lo = 4'he;
        default: lo = 4'($urandom);
      endcase
      d = {$urandom, $urandom};
      s = ($urandom_range(0, 3) == 0) ? d : {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) s[63:32] = d[63:32];
      in_valid = ($urandom_range(0, 7) != 0);
      seq_ack = ($urandom_range(0, 2) == 0);
      opcode = {4'($urandom), lo};
      dst_val = d; src_val = s; imm = ($urandom_range(0, 3) == 0) ? d[31:0] : $urandom;
      offset = 16'($urandom); src_field = 4'($urandom_range(0, 3));
      pc_in = $urandom;
      step();
    end
    seq_ack = 0; in_valid = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule